// File: doc/BRIEF.md
# TDM Serial Highway Interface

This block joins a chip to external full-duplex PCM peripherals, such as ISDN line interfaces, over a serial time-division-multiplexed highway. A frame is divided into 8-bit timeslots. Each timeslot up to the programmed channel count carries one channel. The block serializes outgoing channel bytes, MSB first, and deserializes incoming ones. Both directions run on every bit of the frame at the same time.

The block runs in one of two roles. As bit-clock master, it divides the system clock down to a bit clock and emits a one-bit-wide frame sync at slot 0. As follower, it takes the bit clock and frame sync from the line. The bit rate is set by a divider. The frame rate is set by the number of slots per frame. A 4.096 Mbps line needs a system clock of at least 32.8 MHz. Transmit and receive each have a small FIFO and their own request line toward a DMA engine. A transmit FIFO that runs empty sends an idle pattern. A receive FIFO that is full drops the new byte. Each of these events sets its own sticky flag.

Top module: `tdm_highway`

## Requirements
- R1: While `rst` is high, and just after it: `bclk_out`, `fsync_out`, `ser_tx_oe`, `rx_req`, `tx_underrun` and `rx_overrun` are 0, and `tx_req` is 1.
- R2: In master role (`cfg_master`=1), `bclk_out` toggles every `cfg_div`+1 system cycles, so one bit lasts 2·(`cfg_div`+1) cycles. `cfg_div` must be at least 3.
- R3: In master role, `fsync_out` rises while `bclk_out` is high, stays high for exactly one bit period (the first bit of slot 0), and repeats every 8·`cfg_slots` bits.
- R4: Each slot with index below `cfg_nchan` carries the next byte of the transmit FIFO, MSB first. Data is launched after the rising bit-clock edge. Receive samples `ser_rx` at the falling edge and queues each completed byte in slot order, while transmit runs.
- R5: `ser_tx_oe` is 1 exactly during slots 0 to `cfg_nchan`−1. That is 8·`cfg_nchan` bits per frame. `ser_tx` is 0 while `ser_tx_oe` is 0.
- R6: Bits received in slots at or above `cfg_nchan` are ignored: no byte is queued for them.
- R7: An active slot that starts with the transmit FIFO empty sends the idle pattern 0xFF and sets `tx_underrun`, which stays set until cleared.
- R8: A byte completed while the receive FIFO is full is dropped. The bytes already queued are kept. `rx_overrun` is set and stays set until cleared.
- R9: `err_clr` clears both sticky flags on the next clock edge. A new error in the same cycle wins over the clear.
- R10: `tx_req` is 1 while the transmit FIFO has room. A write with `tx_wr` is taken only then. `rx_req` is 1 while the receive FIFO holds a byte. `rx_rdata` shows the oldest byte, and `rx_rd` removes it.
- R11: In follower role, `bclk_in` and `fsync_in` set the timing, and `bclk_out` and `fsync_out` stay 0. When `fsync_in` is sampled high at a falling edge, that bit becomes bit 0 of slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_master | input | 1 | 1: generate bit clock and sync; 0: follow the line |
| cfg_div | input | DIV_W | Bit-clock half period minus one, in system cycles |
| cfg_slots | input | CNT_W | Timeslots per frame (1..MAX_SLOTS) |
| cfg_nchan | input | CNT_W | Active channels, the slots 0..cfg_nchan−1 |
| err_clr | input | 1 | Clears the sticky error flags |
| bclk_in | input | 1 | Line bit clock in follower role |
| fsync_in | input | 1 | Line frame sync in follower role |
| bclk_out | output | 1 | Generated bit clock (master role) |
| fsync_out | output | 1 | Generated frame sync (master role) |
| ser_tx | output | 1 | Serial transmit data |
| ser_tx_oe | output | 1 | Transmit driver enable; low means high impedance |
| ser_rx | input | 1 | Serial receive data |
| tx_req | output | 1 | Transmit FIFO has room |
| tx_wr | input | 1 | Write strobe for transmit FIFO |
| tx_wdata | input | SLOT_W | Transmit byte |
| rx_req | output | 1 | Receive FIFO holds data |
| rx_rd | input | 1 | Read strobe for receive FIFO |
| rx_rdata | output | SLOT_W | Oldest received byte |
| tx_underrun | output | 1 | Sticky transmit underrun flag |
| rx_overrun | output | 1 | Sticky receive overrun flag |

## Verification
A wrong bit or slot counter shows within one frame. The frame-sync interval comes out at the wrong length, the driver enable covers the wrong number of bits, and looped-back bytes come out misordered or shifted. Transmit and receive share one position, so a slip in either one corrupts the very next received byte. FIFO pointer or flag faults show as bytes reaching the scoreboard out of order, duplicated or missing. They also show as a request line that stays asserted when it should not. A flag that fails to hold or to clear is visible at the flag output a single cycle after the event.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  // One-cycle strobes marking bit-clock edges inside the system clock domain
  typedef struct packed {
    logic launch;   // rising edge: put the next bit on the line
    logic sample;   // falling edge: capture the incoming bit
  } bit_evt_t;
endpackage

// File: rtl/tdm_bitclk.sv
module tdm_bitclk
  import tdm_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             master,
  input  logic [DIV_W-1:0] div,
  input  logic             bclk_ext,
  output logic             bclk_o,
  output bit_evt_t         evt
);
  logic [DIV_W-1:0] cnt;
  logic [2:0]       ext_q;   // two sync stages plus previous value

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      bclk_o <= 1'b0;
      ext_q  <= '0;
      evt    <= '0;
    end else begin
      ext_q <= {ext_q[1:0], bclk_ext};
      evt   <= '0;
      if (master) begin
        if (cnt == div) begin
          cnt         <= '0;
          bclk_o      <= ~bclk_o;
          evt.launch  <= ~bclk_o;
          evt.sample  <= bclk_o;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt        <= '0;
        bclk_o     <= 1'b0;
        evt.launch <= ext_q[1] & ~ext_q[2];
        evt.sample <= ~ext_q[1] & ext_q[2];
      end
    end
  end
endmodule

// File: rtl/tdm_framer.sv
module tdm_framer
  import tdm_pkg::*;
#(
  parameter int SLOT_W    = 8,
  parameter int MAX_SLOTS = 32,
  parameter int CNT_W     = $clog2(MAX_SLOTS + 1),
  parameter int BIT_IW    = $clog2(SLOT_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master,
  input  bit_evt_t          evt,
  input  logic [CNT_W-1:0]  cfg_slots,
  input  logic [CNT_W-1:0]  cfg_nchan,
  input  logic              fsync_ext,
  output logic [BIT_IW-1:0] bit_q,
  output logic [CNT_W-1:0]  slot_q,
  output logic              slot_active,
  output logic              pos_upd,
  output logic              fsync_o
);
  logic [1:0] fs_s;
  logic       last_bit, last_slot;

  assign last_bit    = (bit_q == BIT_IW'(SLOT_W - 1));
  assign last_slot   = ({1'b0, slot_q} + 1'b1) >= {1'b0, cfg_slots};
  assign slot_active = (slot_q < cfg_nchan);

  // Reset parks the position on the final bit so the first launch opens slot 0
  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q   <= BIT_IW'(SLOT_W - 1);
      slot_q  <= CNT_W'(MAX_SLOTS - 1);
      fsync_o <= 1'b0;
      pos_upd <= 1'b0;
      fs_s    <= '0;
    end else begin
      fs_s    <= {fs_s[0], fsync_ext};
      pos_upd <= evt.launch;
      if (evt.launch) begin
        fsync_o <= master & last_bit & last_slot;
        if (last_bit) begin
          bit_q  <= '0;
          slot_q <= last_slot ? '0 : slot_q + 1'b1;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end else if (evt.sample && !master && fs_s[1]) begin
        bit_q  <= '0;
        slot_q <= '0;
      end
    end
  end
endmodule

// File: rtl/tdm_fifo.sv
module tdm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4   // power of two
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == (AW+1)'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/tdm_highway.sv
module tdm_highway
  import tdm_pkg::*;
#(
  parameter int SLOT_W    = 8,
  parameter int MAX_SLOTS = 32,
  parameter int DIV_W     = 8,
  parameter int TX_DEPTH  = 4,
  parameter int RX_DEPTH  = 4,
  parameter logic [SLOT_W-1:0] IDLE_PAT = '1,
  localparam int CNT_W  = $clog2(MAX_SLOTS + 1),
  localparam int BIT_IW = $clog2(SLOT_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_master,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [CNT_W-1:0]  cfg_slots,
  input  logic [CNT_W-1:0]  cfg_nchan,
  input  logic              err_clr,
  input  logic              bclk_in,
  input  logic              fsync_in,
  output logic              bclk_out,
  output logic              fsync_out,
  output logic              ser_tx,
  output logic              ser_tx_oe,
  input  logic              ser_rx,
  output logic              tx_req,
  input  logic              tx_wr,
  input  logic [SLOT_W-1:0] tx_wdata,
  output logic              rx_req,
  input  logic              rx_rd,
  output logic [SLOT_W-1:0] rx_rdata,
  output logic              tx_underrun,
  output logic              rx_overrun
);
  bit_evt_t          evt;
  logic [BIT_IW-1:0] bit_q;
  logic [CNT_W-1:0]  slot_q;
  logic              slot_active, pos_upd;

  tdm_bitclk #(.DIV_W(DIV_W)) u_bitclk (
    .clk(clk), .rst(rst), .master(cfg_master), .div(cfg_div),
    .bclk_ext(bclk_in), .bclk_o(bclk_out), .evt(evt)
  );

  tdm_framer #(.SLOT_W(SLOT_W), .MAX_SLOTS(MAX_SLOTS)) u_framer (
    .clk(clk), .rst(rst), .master(cfg_master), .evt(evt),
    .cfg_slots(cfg_slots), .cfg_nchan(cfg_nchan), .fsync_ext(fsync_in),
    .bit_q(bit_q), .slot_q(slot_q), .slot_active(slot_active),
    .pos_upd(pos_upd), .fsync_o(fsync_out)
  );

  // ---------------- transmit ----------------
  logic [SLOT_W-1:0] tx_head, tx_word, tx_sh;
  logic              tx_full, tx_empty, tx_pop, slot_open;

  assign slot_open = pos_upd & slot_active & (bit_q == '0);
  assign tx_pop    = slot_open & ~tx_empty;
  assign tx_word   = tx_empty ? IDLE_PAT : tx_head;
  assign tx_req    = ~tx_full;

  tdm_fifo #(.W(SLOT_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(tx_wr), .wdata(tx_wdata),
    .pop(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh     <= '0;
      ser_tx    <= 1'b0;
      ser_tx_oe <= 1'b0;
    end else if (pos_upd) begin
      ser_tx_oe <= slot_active;
      if (!slot_active) begin
        ser_tx <= 1'b0;
      end else if (bit_q == '0) begin
        ser_tx <= tx_word[SLOT_W-1];
        tx_sh  <= tx_word << 1;
      end else begin
        ser_tx <= tx_sh[SLOT_W-1];
        tx_sh  <= tx_sh << 1;
      end
    end
  end

  // ---------------- receive ----------------
  logic [SLOT_W-1:0] rx_sh, rx_byte;
  logic              rx_full, rx_empty, rx_done, rx_push;

  assign rx_byte = {rx_sh[SLOT_W-2:0], ser_rx};
  assign rx_done = evt.sample & slot_active & (bit_q == BIT_IW'(SLOT_W - 1));
  assign rx_push = rx_done & ~rx_full;
  assign rx_req  = ~rx_empty;

  tdm_fifo #(.W(SLOT_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .wdata(rx_byte),
    .pop(rx_rd), .rdata(rx_rdata), .full(rx_full), .empty(rx_empty)
  );

  always_ff @(posedge clk) begin
    if (rst)                              rx_sh <= '0;
    else if (evt.sample && slot_active)   rx_sh <= rx_byte;
  end

  // ---------------- sticky errors: a new event beats the clear ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_underrun <= 1'b0;
      rx_overrun  <= 1'b0;
    end else begin
      if (slot_open && tx_empty) tx_underrun <= 1'b1;
      else if (err_clr)          tx_underrun <= 1'b0;
      if (rx_done && rx_full)    rx_overrun  <= 1'b1;
      else if (err_clr)          rx_overrun  <= 1'b0;
    end
  end
endmodule

// File: rtl/tdm_highway_chk.sv
module tdm_highway_chk (
  input logic clk,
  input logic rst,
  input logic cfg_master,
  input logic bclk_out,
  input logic fsync_out,
  input logic ser_tx_oe,
  input logic tx_req,
  input logic tx_pop,
  input logic err_clr,
  input logic tx_underrun,
  input logic rx_overrun,
  input logic pos_upd,
  input logic slot_active
);
  // R11: follower role keeps the generated clock quiet
  p_bclk_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !cfg_master |-> !bclk_out);

  // R3: the sync pulse opens during the high phase of the bit clock
  p_fsync_in_high_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(fsync_out) |-> bclk_out);

  // R5: driver enabled only inside an active slot
  p_oe_active_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_master && ser_tx_oe && !pos_upd) |-> slot_active);

  // R7: underrun flag holds until cleared
  p_underrun_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (tx_underrun && !err_clr) |=> tx_underrun);

  // R8: overrun flag holds until cleared
  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_overrun && !err_clr) |=> rx_overrun);

  // R10: a full transmit queue stays full until a byte leaves
  p_txreq_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!tx_req && !tx_pop) |=> !tx_req);
endmodule

bind tdm_highway tdm_highway_chk u_chk (
  .clk(clk), .rst(rst), .cfg_master(cfg_master), .bclk_out(bclk_out),
  .fsync_out(fsync_out), .ser_tx_oe(ser_tx_oe), .tx_req(tx_req),
  .tx_pop(tx_pop), .err_clr(err_clr), .tx_underrun(tx_underrun),
  .rx_overrun(rx_overrun), .pos_upd(pos_upd), .slot_active(slot_active)
);

// File: tb/test_tdm_highway.sv
module test_tdm_highway;
  localparam int SLOT_W = 8;
  localparam int CNT_W  = 6;
  localparam int DIV_W  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_master = 1'b1;
  logic [DIV_W-1:0] cfg_div = 8'd3;
  logic [CNT_W-1:0] cfg_slots = 6'd4;
  logic [CNT_W-1:0] cfg_nchan = 6'd2;
  logic err_clr = 1'b0;
  logic bclk_in = 1'b0, fsync_in = 1'b0, ext_rx = 1'b0, lb = 1'b1;
  logic bclk_out, fsync_out, ser_tx, ser_tx_oe, ser_rx;
  logic tx_req, rx_req, tx_underrun, rx_overrun;
  logic tx_wr = 1'b0, rx_rd = 1'b0;
  logic [SLOT_W-1:0] tx_wdata = '0;
  logic [SLOT_W-1:0] rx_rdata;

  always #5 clk = ~clk;

  assign ser_rx = lb ? (ser_tx_oe ? ser_tx : 1'b1) : ext_rx;

  tdm_highway i_tdm_highway (
    .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_div(cfg_div),
    .cfg_slots(cfg_slots), .cfg_nchan(cfg_nchan), .err_clr(err_clr),
    .bclk_in(bclk_in), .fsync_in(fsync_in), .bclk_out(bclk_out),
    .fsync_out(fsync_out), .ser_tx(ser_tx), .ser_tx_oe(ser_tx_oe),
    .ser_rx(ser_rx), .tx_req(tx_req), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
    .rx_req(rx_req), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
    .tx_underrun(tx_underrun), .rx_overrun(rx_overrun)
  );

  int n_tests = 0, n_fail = 0;
  int idle_seen = 0;
  bit mon_en = 1'b0, quiet_bad = 1'b0;
  logic [SLOT_W-1:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: pops every received byte and compares it
  initial begin
    logic [SLOT_W-1:0] e;
    forever begin
      @(negedge clk);
      if (!rst && !cfg_master && (bclk_out || fsync_out)) quiet_bad = 1'b1;
      if (mon_en && !rst && rx_req) begin
        if (exp_q.size() > 0) begin
          e = exp_q.pop_front();
          chk(rx_rdata == e, "R4 R6 R8 received byte", rx_rdata, e);
        end else begin
          chk(rx_rdata == 8'hFF, "R7 idle byte", rx_rdata, 8'hFF);
          idle_seen++;
        end
        rx_rd = 1'b1;
      end else begin
        rx_rd = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  function automatic bit sig(input int sel);
    return (sel == 0) ? bclk_out : (sel == 1) ? fsync_out : ser_tx_oe;
  endfunction

  task automatic wait_rise(input int sel);
    bit p, c;
    c = sig(sel); p = c;
    while (!(c && !p)) begin
      p = c; @(negedge clk); c = sig(sel);
    end
  endtask

  task automatic rise_gap(input int sel, output int n);
    bit p, c;
    wait_rise(sel);
    c = 1'b1; n = 0;
    do begin
      p = c; @(negedge clk); c = sig(sel); n++;
    end while (!(c && !p));
  endtask

  task automatic oe_bits(input int nbits, output int n);
    bit p, c;
    n = 0; c = bclk_out;
    for (int k = 0; k < nbits; k++) begin
      do begin p = c; @(negedge clk); c = bclk_out; end while (!(p && !c));
      if (ser_tx_oe) n++;
    end
  endtask

  task automatic do_reset(input bit m, input int d, input int s, input int nc, input bit l);
    @(negedge clk);
    rst = 1'b1; mon_en = 1'b0; tx_wr = 1'b0; err_clr = 1'b0;
    cfg_master = m; cfg_div = DIV_W'(d); cfg_slots = CNT_W'(s); cfg_nchan = CNT_W'(nc);
    lb = l; bclk_in = 1'b0; fsync_in = 1'b0; ext_rx = 1'b0;
    exp_q.delete(); idle_seen = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
  endtask

  // Driver: writes bytes while the queue has room, records expectations
  task automatic feed(input int n, input int base, input int keep);
    for (int i = 0; i < n; i++) begin
      while (!tx_req) begin tx_wr = 1'b0; @(negedge clk); end
      tx_wr = 1'b1; tx_wdata = SLOT_W'(base + i);
      if (i < keep) exp_q.push_back(SLOT_W'(base + i));
      @(negedge clk);
    end
    tx_wr = 1'b0;
  endtask

  task automatic wait_drain(input int min_idle);
    int t = 0;
    while ((exp_q.size() != 0 || idle_seen < min_idle) && t < 5000) begin
      @(negedge clk); t++;
    end
  endtask

  task automatic send_frame(input logic [7:0] b0, input logic [7:0] b1);
    for (int s = 0; s < 4; s++) begin
      for (int b = 7; b >= 0; b--) begin
        fsync_in = (s == 0 && b == 7);
        ext_rx   = (s == 0) ? b0[b] : (s == 1) ? b1[b] : 1'b0;
        bclk_in  = 1'b1;
        repeat (5) @(negedge clk);
        bclk_in  = 1'b0;
        repeat (5) @(negedge clk);
      end
    end
    fsync_in = 1'b0;
  endtask

  initial begin
    int n;
    // ---- R1: reset state ----
    repeat (3) @(negedge clk);
    chk(bclk_out == 0, "R1 bclk_out", bclk_out, 0);
    chk(fsync_out == 0, "R1 fsync_out", fsync_out, 0);
    chk(ser_tx_oe == 0, "R1 ser_tx_oe", ser_tx_oe, 0);
    chk(tx_req == 1, "R1 tx_req", tx_req, 1);
    chk(rx_req == 0, "R1 rx_req", rx_req, 0);
    chk(tx_underrun == 0 && rx_overrun == 0, "R1 flags", {tx_underrun, rx_overrun}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ser_tx_oe == 0 && tx_req == 1, "R1 after release", {ser_tx_oe, tx_req}, 1);

    // ---- phase 1: master, div 3, 4 slots, 2 channels, loopback ----
    do_reset(1, 3, 4, 2, 1);
    mon_en = 1'b1;
    fork
      feed(12, 8'h40, 12);
      begin
        rise_gap(0, n); chk(n == 8, "R2 bit period div3", n, 8);
        rise_gap(1, n); chk(n == 256, "R3 frame interval", n, 256);
        wait_rise(1); n = 1; @(negedge clk);
        while (fsync_out) begin n++; @(negedge clk); end
        chk(n == 8, "R3 sync width", n, 8);
        wait_rise(1); oe_bits(32, n);
        chk(n == 16, "R5 enabled bits per frame", n, 16);
      end
    join
    wait_drain(2);
    chk(exp_q.size() == 0, "R4 all bytes received", exp_q.size(), 0);
    chk(tx_underrun == 1, "R7 underrun flag", tx_underrun, 1);
    chk(rx_overrun == 0, "R8 no overrun while drained", rx_overrun, 0);

    // ---- phase 2: div 5, 2 slots, 1 channel ----
    do_reset(1, 5, 2, 1, 1);
    mon_en = 1'b1;
    fork
      feed(3, 8'hA0, 3);
      begin
        rise_gap(0, n); chk(n == 12, "R2 bit period div5", n, 12);
        rise_gap(1, n); chk(n == 192, "R3 short frame interval", n, 192);
        wait_rise(1); oe_bits(16, n);
        chk(n == 8, "R5 one enabled slot", n, 8);
      end
    join
    wait_drain(2);
    chk(exp_q.size() == 0, "R6 only active slot queued", exp_q.size(), 0);
    chk(tx_underrun == 1, "R7 underrun second pattern", tx_underrun, 1);

    // ---- phase 3: overrun, then clearing ----
    do_reset(1, 3, 4, 2, 1);
    feed(6, 8'h10, 4);
    n = 0;
    while (!rx_overrun && n < 2000) begin @(negedge clk); n++; end
    chk(rx_overrun == 1, "R8 overrun flag", rx_overrun, 1);
    chk(rx_req == 1, "R10 rx_req with data", rx_req, 1);
    repeat (300) @(negedge clk);
    mon_en = 1'b1;
    wait_drain(1);
    chk(exp_q.size() == 0, "R8 retained bytes", exp_q.size(), 0);
    chk(rx_overrun == 1, "R8 flag still set", rx_overrun, 1);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    chk(rx_overrun == 0, "R9 overrun cleared", rx_overrun, 0);
    repeat (200) @(negedge clk);
    chk(rx_overrun == 0, "R9 overrun stays clear", rx_overrun, 0);
    wait_rise(2);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    chk(tx_underrun == 0, "R9 underrun cleared", tx_underrun, 0);
    repeat (100) @(negedge clk);
    chk(tx_underrun == 1, "R7 underrun sets again", tx_underrun, 1);

    // ---- phase 4: follower role ----
    do_reset(0, 3, 4, 2, 0);
    quiet_bad = 1'b0;
    mon_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tx_wr = 1'b1; tx_wdata = SLOT_W'(i); @(negedge clk);
    end
    tx_wr = 1'b0;
    chk(tx_req == 0, "R10 tx_req low when full", tx_req, 0);
    exp_q.push_back(8'h5A); exp_q.push_back(8'hC3); send_frame(8'h5A, 8'hC3);
    exp_q.push_back(8'h01); exp_q.push_back(8'h80); send_frame(8'h01, 8'h80);
    exp_q.push_back(8'hE7); exp_q.push_back(8'h3C); send_frame(8'hE7, 8'h3C);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R11 follower bytes", exp_q.size(), 0);
    chk(quiet_bad == 0, "R11 outputs quiet", quiet_bad, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule